// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Timing Engine

This block is a bus master for an external memory device whose low address bits share pins with its 16-bit data bus. A host hands it one access at a time over a request/acknowledge interface, with a word address, write data and byte enables. The engine then runs a single synchronous write or a single read. A five-bit cycle counter starts at zero when the access begins, and every control strobe is decoded from that count against programmable on and off points.

On the shared bus the address comes first. For a write, the data replaces it at a programmable cycle. For a read, the engine stops driving the bus and flips the direction output in the cycle that output-enable asserts. The read word is captured at a programmable access cycle. While the bus is idle, the engine keeps driving the last word it read. An active-low wait input freezes the access in place. The host receives a one-cycle acknowledge when the programmed cycle time runs out.

Top module: `muxbus_engine`

## Requirements
- R1: In the first cycle of an access (count 0), `busOut` carries `hostAddr[15:0]` with `busOe`=1, and `memAddr` carries `hostAddr[25:16]`.
- R2: During a write, `busOut` carries the low address while count < `wrDataOn`, and carries the latched write data from count = `wrDataOn` until the access ends.
- R3: Each active-low strobe is low exactly while on ≤ count < off. `csN` uses `csOffWr` or `csOffRd` according to direction, and `advN` uses `advOffWr` or `advOffRd` the same way. `weN` can go low only on writes and `oeN` only on reads. An off value ≤ its on value gives no pulse at all. Outside an access, every strobe is 1.
- R4: `beN` equals the bitwise inverse of the latched `hostBe` (bit 1 = upper byte) while `csN` is 0, and 2'b11 otherwise.
- R5: An access spans N = max(cycle time, 1) counted cycles, using `wrCycle` for writes and `rdCycle` for reads. `hostAck` is 1 for exactly the one cycle after the last counted cycle.
- R6: `dirIn` (1 = bus input) is 1 exactly during a read at count ≥ `oeOn`, and `busOe` is 0 whenever `dirIn` is 1. Outside such cycles `dirIn` is 0.
- R7: The bus word present at `busIn` during the read cycle with count = `rdAccess` is captured, provided wait is high at that edge. It appears on `rdData` from the acknowledge cycle on.
- R8: While no access is running, `busOe`=1 and `busOut` equals the last captured read word (0 after reset).
- R9: A clock edge that samples `waitN`=0 during an access does not advance the count, so every strobe and bus output holds its value.
- R10: `hostReq` is accepted only when no access is running. A request made during an access is dropped and produces no later access or acknowledge.
- R11: After reset, all strobes are 1, `beN`=2'b11, `dirIn`=0, `hostAck`=0, `busOe`=1 and `busOut`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| hostReq | input | 1 | Access request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 26 | Word address |
| hostWdata | input | 16 | Write data |
| hostBe | input | 2 | Byte enables, bit 1 upper byte |
| hostAck | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last captured read word |
| csOn | input | 5 | Chip-select assert cycle |
| csOffWr | input | 5 | Chip-select release cycle, writes |
| csOffRd | input | 5 | Chip-select release cycle, reads |
| advOn | input | 5 | Address-valid assert cycle |
| advOffWr | input | 5 | Address-valid release cycle, writes |
| advOffRd | input | 5 | Address-valid release cycle, reads |
| weOn | input | 5 | Write-enable assert cycle |
| weOff | input | 5 | Write-enable release cycle |
| oeOn | input | 5 | Output-enable assert cycle |
| oeOff | input | 5 | Output-enable release cycle |
| rdAccess | input | 5 | Read capture cycle |
| wrDataOn | input | 5 | Cycle at which write data replaces address |
| wrCycle | input | 5 | Write access length |
| rdCycle | input | 5 | Read access length |
| waitN | input | 1 | Wait from device, active low |
| memAddr | output | 10 | Upper address bits |
| busOut | output | 16 | Shared bus drive value |
| busOe | output | 1 | Shared bus drive enable |
| busIn | input | 16 | Shared bus sampled value |
| csN | output | 1 | Chip select, active low |
| advN | output | 1 | Address valid, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| beN | output | 2 | Byte enables, active low |
| dirIn | output | 1 | Bus direction, 1 = input |

## Verification
A request raised before edge E is accepted at E, and count 0 is visible in the cycle after E. Every strobe and bus value for count k follows k edges later, plus one more edge for each stalled cycle. The bench drives inputs and samples outputs only on falling edges. It advances its own expected count only on cycles where it left wait high, and compares every output against the window rules at that count. The acknowledge and the captured read word are checked in the single cycle after the last counted cycle, the pulse's end one cycle later, and the bus-keeping value during the idle cycles that follow.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic load;      // request accepted at this edge
    logic active;    // access in progress
    logic dataPhase; // write data replaces address on the bus
    logic capture;   // latch bus input at this edge
    logic drvBus;    // engine drives the shared bus
    logic csAct;     // chip select asserted
  } strobe_t;
endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostWrite,
  input  logic          waitN,
  input  logic [TW-1:0] csOn,
  input  logic [TW-1:0] csOffWr,
  input  logic [TW-1:0] csOffRd,
  input  logic [TW-1:0] advOn,
  input  logic [TW-1:0] advOffWr,
  input  logic [TW-1:0] advOffRd,
  input  logic [TW-1:0] weOn,
  input  logic [TW-1:0] weOff,
  input  logic [TW-1:0] oeOn,
  input  logic [TW-1:0] oeOff,
  input  logic [TW-1:0] rdAccess,
  input  logic [TW-1:0] wrDataOn,
  input  logic [TW-1:0] wrCycle,
  input  logic [TW-1:0] rdCycle,
  output strobe_t       stb,
  output logic          csN,
  output logic          advN,
  output logic          weN,
  output logic          oeN,
  output logic          dirIn,
  output logic          hostAck,
  output logic          busy
);
  logic          active;
  logic          isWr;
  logic [TW-1:0] cnt;
  logic [TW-1:0] csOff;
  logic [TW-1:0] advOff;
  logic [TW-1:0] cycLen;
  logic          lastCyc;

  function automatic logic inWin(input logic [TW-1:0] c, input logic [TW-1:0] on,
                                 input logic [TW-1:0] off);
    return (c >= on) && (c < off);
  endfunction

  always_comb begin
    csOff   = isWr ? csOffWr : csOffRd;
    advOff  = isWr ? advOffWr : advOffRd;
    cycLen  = isWr ? wrCycle : rdCycle;
    lastCyc = ({1'b0, cnt} + 1'b1) >= {1'b0, cycLen};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      isWr    <= 1'b0;
      cnt     <= '0;
      hostAck <= 1'b0;
    end else begin
      hostAck <= 1'b0;
      if (!active) begin
        if (hostReq) begin
          active <= 1'b1;
          isWr   <= hostWrite;
          cnt    <= '0;
        end
      end else if (waitN) begin
        if (lastCyc) begin
          active  <= 1'b0;
          hostAck <= 1'b1;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    csN   = !(active && inWin(cnt, csOn, csOff));
    advN  = !(active && inWin(cnt, advOn, advOff));
    weN   = !(active && isWr && inWin(cnt, weOn, weOff));
    oeN   = !(active && !isWr && inWin(cnt, oeOn, oeOff));
    dirIn = active && !isWr && (cnt >= oeOn);
    busy  = active;
    stb.load      = !active && hostReq;
    stb.active    = active;
    stb.dataPhase = isWr && (cnt >= wrDataOn);
    stb.capture   = active && !isWr && waitN && (cnt == rdAccess);
    stb.drvBus    = !dirIn;
    stb.csAct     = !csN;
  end
endmodule

// File: rtl/muxbus_dpath.sv
module muxbus_dpath
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [DATA_W-1:0]        hostWdata,
  input  logic [BE_W-1:0]          hostBe,
  input  logic [DATA_W-1:0]        busIn,
  output logic [ADDR_W-DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe,
  output logic [BE_W-1:0]          beN,
  output logic [DATA_W-1:0]        rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BE_W-1:0]   beQ;
  logic [DATA_W-1:0] keepQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
      keepQ <= '0;
    end else begin
      if (stb.load) begin
        addrQ <= hostAddr;
        dataQ <= hostWdata;
        beQ   <= hostBe;
      end
      if (stb.capture) keepQ <= busIn;
    end
  end

  always_comb begin
    memAddr = addrQ[ADDR_W-1:DATA_W];
    if (!stb.active)       busOut = keepQ;
    else if (stb.dataPhase) busOut = dataQ;
    else                    busOut = addrQ[DATA_W-1:0];
    busOe  = stb.drvBus;
    beN    = stb.csAct ? ~beQ : '1;
    rdData = keepQ;
  end
endmodule

// File: rtl/muxbus_engine.sv
module muxbus_engine
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int TW     = 5,
  localparam int BE_W  = DATA_W / 8,
  localparam int UP_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [BE_W-1:0]   hostBe,
  output logic              hostAck,
  output logic [DATA_W-1:0] rdData,
  input  logic [TW-1:0]     csOn,
  input  logic [TW-1:0]     csOffWr,
  input  logic [TW-1:0]     csOffRd,
  input  logic [TW-1:0]     advOn,
  input  logic [TW-1:0]     advOffWr,
  input  logic [TW-1:0]     advOffRd,
  input  logic [TW-1:0]     weOn,
  input  logic [TW-1:0]     weOff,
  input  logic [TW-1:0]     oeOn,
  input  logic [TW-1:0]     oeOff,
  input  logic [TW-1:0]     rdAccess,
  input  logic [TW-1:0]     wrDataOn,
  input  logic [TW-1:0]     wrCycle,
  input  logic [TW-1:0]     rdCycle,
  input  logic              waitN,
  output logic [UP_W-1:0]   memAddr,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] busIn,
  output logic              csN,
  output logic              advN,
  output logic              weN,
  output logic              oeN,
  output logic [BE_W-1:0]   beN,
  output logic              dirIn
);
  strobe_t stb;
  logic    busy;

  muxbus_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite), .waitN(waitN),
    .csOn(csOn), .csOffWr(csOffWr), .csOffRd(csOffRd),
    .advOn(advOn), .advOffWr(advOffWr), .advOffRd(advOffRd),
    .weOn(weOn), .weOff(weOff), .oeOn(oeOn), .oeOff(oeOff),
    .rdAccess(rdAccess), .wrDataOn(wrDataOn), .wrCycle(wrCycle), .rdCycle(rdCycle),
    .stb(stb), .csN(csN), .advN(advN), .weN(weN), .oeN(oeN), .dirIn(dirIn),
    .hostAck(hostAck), .busy(busy)
  );

  muxbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostBe(hostBe), .busIn(busIn), .memAddr(memAddr), .busOut(busOut), .busOe(busOe),
    .beN(beN), .rdData(rdData)
  );
endmodule

// File: rtl/muxbus_checker.sv
module muxbus_checker #(
  parameter int DATA_W = 16,
  parameter int UP_W   = 10,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              hostAck,
  input logic              waitN,
  input logic              csN,
  input logic              advN,
  input logic              weN,
  input logic              oeN,
  input logic              dirIn,
  input logic              busOe,
  input logic [BE_W-1:0]   beN,
  input logic [UP_W-1:0]   memAddr,
  input logic [DATA_W-1:0] busOut,
  input logic [DATA_W-1:0] rdData
);
  // R5: acknowledge lasts a single cycle and marks the end of the access
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);
  p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> !busy);

  // R3: no strobe is active while idle; write and read enables never overlap
  p_idle_strobes_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && advN && weN && oeN));
  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !oeN));

  // R4: byte enables only with chip select
  p_be_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (beN == '1));

  // R6: output enable implies input direction, and input direction releases the bus
  p_oe_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> dirIn);
  p_dir_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    dirIn |-> !busOe);

  // R8: idle bus carries the kept read word
  p_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busOe && busOut == rdData));

  // R9: a stalled edge leaves every output unchanged
  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !waitN) |=> ($stable({csN, advN, weN, oeN, dirIn, busOe, busOut}) && busy));

  // R10: the upper address does not move during an access
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr));
endmodule

bind muxbus_engine muxbus_checker #(.DATA_W(DATA_W), .UP_W(UP_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .hostAck(hostAck), .waitN(waitN),
  .csN(csN), .advN(advN), .weN(weN), .oeN(oeN), .dirIn(dirIn), .busOe(busOe),
  .beN(beN), .memAddr(memAddr), .busOut(busOut), .rdData(rdData)
);

// File: tb/tb_muxbus_engine.sv
module tb_muxbus_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rstN = 0;
  logic hostReq = 0, hostWrite = 0;
  logic [25:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [1:0]  hostBe = '0;
  logic hostAck;
  logic [15:0] rdData;
  logic [4:0] csOn = 0, csOffWr = 0, csOffRd = 0, advOn = 0, advOffWr = 0, advOffRd = 0;
  logic [4:0] weOn = 0, weOff = 0, oeOn = 0, oeOff = 0, rdAccess = 0, wrDataOn = 0;
  logic [4:0] wrCycle = 0, rdCycle = 0;
  logic waitN = 1;
  logic [9:0] memAddr;
  logic [15:0] busOut, busIn = '0;
  logic busOe, csN, advN, weN, oeN, dirIn;
  logic [1:0] beN;

  int checks = 0, errors = 0;
  logic [15:0] keepExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_engine dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(input int k, input int on, input int off);
    return (k >= on) && (k < off);
  endfunction

  // Runs one access; checks every counted cycle, the ack cycle and the cycle after.
  task automatic runAcc(input bit wr, input logic [25:0] a, input logic [15:0] d,
                        input logic [1:0] be, input int stallAt, input int stallLen,
                        input bit inject);
    int len, k, st, cOff, aOff;
    len  = wr ? ((wrCycle == 0) ? 1 : int'(wrCycle)) : ((rdCycle == 0) ? 1 : int'(rdCycle));
    cOff = wr ? int'(csOffWr) : int'(csOffRd);
    aOff = wr ? int'(advOffWr) : int'(advOffRd);
    @(negedge clk);
    hostReq = 1; hostWrite = wr; hostAddr = a; hostWdata = d; hostBe = be;
    @(negedge clk);
    hostReq = 0;
    k = 0; st = 0;
    while (k < len) begin
      bit c, dIn;
      c   = win(k, csOn, cOff);
      dIn = !wr && (k >= int'(oeOn));
      chk(csN == !c, "R3 csN", csN, !c);
      chk(advN == !win(k, advOn, aOff), "R3 advN", advN, !win(k, advOn, aOff));
      chk(weN == !(wr && win(k, weOn, weOff)), "R3 weN", weN, !(wr && win(k, weOn, weOff)));
      chk(oeN == !(!wr && win(k, oeOn, oeOff)), "R3 oeN", oeN, !(!wr && win(k, oeOn, oeOff)));
      chk(beN == (c ? ~be : 2'b11), "R4 beN", beN, c ? ~be : 2'b11);
      chk(dirIn == dIn, "R6 dirIn", dirIn, dIn);
      chk(hostAck == 0, "R5 early ack", hostAck, 0);
      chk(memAddr == a[25:16], "R1 memAddr", memAddr, a[25:16]);
      if (dIn) chk(busOe == 0, "R6 busOe", busOe, 0);
      else if (wr && k >= int'(wrDataOn)) chk(busOe && busOut == d, "R2 data", busOut, d);
      else chk(busOe && busOut == a[15:0], k == 0 ? "R1 addr" : "R2 addr", busOut, a[15:0]);
      if (!wr) busIn = 16'hA000 + 16'(k) + 16'(st << 8);
      if (inject && k == 2) begin hostReq = 1; hostAddr = 26'h3FF_FFFF; end
      else hostReq = 0;
      if (k == stallAt && st < stallLen) begin
        waitN = 0; st++;
      end else begin
        waitN = 1;
        if (!wr && k == int'(rdAccess)) keepExp = busIn;
        k++;
      end
      @(negedge clk);
    end
    hostReq = 0; waitN = 1;
    chk(hostAck == 1, "R5 ack", hostAck, 1);
    chk(csN && weN && oeN && advN, "R3 idle strobes", {csN, advN, weN, oeN}, 4'hF);
    chk(dirIn == 0, "R6 dir back to out", dirIn, 0);
    if (!wr) chk(rdData == keepExp, "R7 rdData", rdData, keepExp);
    chk(busOe && busOut == keepExp, "R8 keep", busOut, keepExp);
    @(negedge clk);
    chk(hostAck == 0, "R5 ack width", hostAck, 0);
    chk(busOe && busOut == keepExp, "R8 keep idle", busOut, keepExp);
  endtask

  task automatic t_reset();
    chk(csN && advN && weN && oeN, "R11 strobes", {csN, advN, weN, oeN}, 4'hF);
    chk(beN == 2'b11, "R11 beN", beN, 2'b11);
    chk(dirIn == 0 && hostAck == 0, "R11 dir/ack", {dirIn, hostAck}, 0);
    chk(busOe == 1 && busOut == 0, "R11 bus", busOut, 0);
  endtask

  task automatic t_write_basic();
    csOn = 0; csOffWr = 7; advOn = 0; advOffWr = 2; weOn = 3; weOff = 7;
    wrDataOn = 3; wrCycle = 8;
    runAcc(1, 26'h2A5_1234, 16'hBEEF, 2'b11, -1, 0, 0);
  endtask

  task automatic t_write_zero_we();
    csOn = 1; csOffWr = 5; advOn = 2; advOffWr = 1; weOn = 4; weOff = 4;
    wrDataOn = 1; wrCycle = 6;
    runAcc(1, 26'h155_8001, 16'h0F0F, 2'b01, -1, 0, 0);
  endtask

  task automatic t_read_basic();
    csOn = 1; csOffRd = 9; advOn = 1; advOffRd = 3; oeOn = 4; oeOff = 9;
    rdAccess = 7; rdCycle = 10;
    runAcc(0, 26'h0C3_4567, 16'h0, 2'b10, -1, 0, 0);
  endtask

  task automatic t_read_wait();
    // R9: stall two edges at count 5, then confirm the capture still tracks count
    runAcc(0, 26'h3E0_00FF, 16'h0, 2'b11, 5, 2, 0);
    // R9: stall on the capture cycle itself
    runAcc(0, 26'h001_0002, 16'h0, 2'b11, 7, 3, 0);
  endtask

  task automatic t_ignore_req();
    // R10: request raised mid-access must not start a second access
    runAcc(1, 26'h0AA_5555, 16'h1234, 2'b11, -1, 0, 1);
    for (int i = 0; i < 5; i++) begin
      chk(csN && hostAck == 0, "R10 dropped request", {csN, hostAck}, 2'b10);
      @(negedge clk);
    end
  endtask

  task automatic t_zero_cycle();
    // R5: cycle time 0 behaves as 1
    csOn = 0; csOffWr = 1; advOn = 0; advOffWr = 1; weOn = 0; weOff = 1;
    wrDataOn = 0; wrCycle = 0;
    runAcc(1, 26'h111_2222, 16'h3333, 2'b10, -1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_write_basic();
    t_write_zero_we();
    t_read_basic();
    t_read_wait();
    t_ignore_req();
    t_zero_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule